// File: doc/BRIEF.md
# Audio Codec Link Slot Frame Transmitter

This block drives the outbound serial line of an audio codec link. It runs on the bit clock that the codec supplies, and it repeats a frame of 256 bit times with no gap between frames. Each frame opens with a 16-bit tag slot, and the tag slot says which payload slots carry data in that frame. Payload slots 1 to 4 follow, 20 bits each. The rest of the frame is filled with zeros. A frame-sync output marks the tag slot.

Software or a DMA engine loads the payload through a simple write strobe, one holding register per slot. A write marks that slot's buffer as full. At each frame start, the block takes the slot-request bits that the receive side captured from the previous inbound frame. Only the requested slots are copied into the outgoing frame. A requested slot whose buffer was never refilled still sends its old sample, and the block raises a sticky underrun flag for that slot.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame is 256 bit clocks long and frames follow each other without a gap. `frameSync` is high for the first 16 bit times of each frame and low for the other 240.
- R2: Serial bit 0 of the frame (tag bit 15) is 1 when at least one payload slot is sent in the frame. Serial bits 1 to 4 (tag bits 14 down to 11) are 1 for slots 1 to 4 that are sent. Serial bits 5 to 15 are always 0.
- R3: Slot n (n = 1 to 4) is sent only when `slotReq[n-1]` is high at the frame-start edge. Slots that are not requested, and all bits from serial bit 96 onward, are 0.
- R4: A sent slot n occupies serial bits 16+20(n-1) up to 35+20(n-1), MSB first. It carries `wrData[19:0]` from the last write to that slot. `wrData[31:20]` has no effect on the output.
- R5: A write with `wrEn` high and `wrSlot` = n-1 (codes 0 to 3 select slots 1 to 4) loads that slot's holding register and sets `bufFull[n-1]` on the next edge.
- R6: At a frame start, `bufFull` bits are cleared for the requested slots. Bits of slots that are not requested keep their value. `bufFull` bits never fall at any other edge.
- R7: When a requested slot has `bufFull` low at frame start, its `underrun` bit is set at that edge, and the slot still sends its holding-register contents.
- R8: An `underrun` bit stays high until a cycle with its `urClr` bit high. If a new underrun and a clear happen at the same edge, the set wins.
- R9: A write that coincides with the frame-start edge does not change the data sent in that frame. The new data is kept, and the slot's `bufFull` bit stays set.
- R10: While `rstN` is low, `sdata`, `frameSync`, `bufFull` and `underrun` are 0. The first edge after reset starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock from the codec. Outputs are launched on its rising edge. |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for a slot holding register |
| wrSlot | input | 2 | Slot to write (0 to 3 select slots 1 to 4) |
| wrData | input | 32 | Write data. Only bits 19:0 are used. |
| slotReq | input | 4 | Slot-request bits from the previous received frame. Bit 0 is slot 1. |
| urClr | input | 4 | Per-slot clear of the underrun flags |
| sdata | output | 1 | Serial frame data |
| frameSync | output | 1 | High during the tag slot |
| bufFull | output | 4 | Per-slot flag: a new sample is waiting |
| underrun | output | 4 | Per-slot sticky underrun flags |

## Verification
A wrong bit counter shows up first on `frameSync`. Its width or its period goes wrong within a single frame, and every later slot boundary is shifted, so whole serial fields no longer match. A wrong full or underrun state cannot stay hidden for long. It shows at the next frame start: either a tag bit is set or missing, or an `underrun` bit rises without reason, or a `bufFull` bit fails to drop. The sweep cycles through all sixteen request patterns and a rotating set of write masks. It also places writes and clears exactly on the frame-start edge, so ordering mistakes are caught within one frame of the point where they arise.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic frameStart;  // first bit time of a frame: load the shift register
    logic inTag;       // current bit time lies inside the tag slot
  } txStrobe_t;

endpackage

// File: rtl/aclink_tx_ctrl.sv
module aclink_tx_ctrl
  import aclink_tx_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int TAG_W      = 16
) (
  input  logic      bitClk,
  input  logic      rstN,
  output txStrobe_t strobe
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_W);

  logic [CNT_W-1:0] bitCnt;

  // bitCnt holds the position of the bit launched at the coming edge
  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (bitCnt == LAST_BIT) begin
      bitCnt <= '0;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.frameStart = (bitCnt == '0);
    strobe.inTag      = (bitCnt < TAG_END);
  end

endmodule

// File: rtl/aclink_tx_dpath.sv
module aclink_tx_dpath
  import aclink_tx_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16,
  parameter int WR_W   = 32
) (
  input  logic                       bitClk,
  input  logic                       rstN,
  input  txStrobe_t                  strobe,
  input  logic                       wrEn,
  input  logic [$clog2(SLOTS)-1:0]   wrSlot,
  input  logic [WR_W-1:0]            wrData,
  input  logic [SLOTS-1:0]           slotReq,
  input  logic [SLOTS-1:0]           urClr,
  output logic                       sdata,
  output logic                       frameSync,
  output logic [SLOTS-1:0]           bufFull,
  output logic [SLOTS-1:0]           underrun
);

  localparam int IDX_W = $clog2(SLOTS);
  localparam int PAY_W = TAG_W + SLOTS * SLOT_W;

  logic [SLOT_W-1:0] holdR [SLOTS];
  logic [SLOTS-1:0]  fullR;
  logic [SLOTS-1:0]  urR;
  logic [PAY_W-1:0]  loadVec;
  logic [PAY_W-1:0]  shiftR;
  logic              sdataR;
  logic              syncR;
  logic              wrDataUnused;

  // Bits above the sample width are accepted but not stored
  assign wrDataUnused = ^wrData[WR_W-1:SLOT_W];

  // Per-slot holding register, full flag and sticky underrun flag
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic hit;
    logic send;
    assign hit  = wrEn && (wrSlot == IDX_W'(i));
    assign send = strobe.frameStart && slotReq[i];

    always_ff @(posedge bitClk) begin
      if (!rstN) begin
        holdR[i] <= '0;
        fullR[i] <= 1'b0;
        urR[i]   <= 1'b0;
      end else begin
        if (hit) begin
          holdR[i] <= wrData[SLOT_W-1:0];
        end
        // A write on the load edge wins: the new sample waits for the next frame
        if (hit) begin
          fullR[i] <= 1'b1;
        end else if (send) begin
          fullR[i] <= 1'b0;
        end
        // Setting has priority over software clear
        if (send && !fullR[i]) begin
          urR[i] <= 1'b1;
        end else if (urClr[i]) begin
          urR[i] <= 1'b0;
        end
      end
    end
  end

  // Tag word and requested payload, in serial order from the MSB down
  always_comb begin
    loadVec = '0;
    loadVec[PAY_W-1] = |slotReq;
    for (int i = 0; i < SLOTS; i++) begin
      loadVec[PAY_W-2-i] = slotReq[i];
      if (slotReq[i]) begin
        loadVec[PAY_W-TAG_W-1-i*SLOT_W -: SLOT_W] = holdR[i];
      end
    end
  end

  // Serialiser: zeros shift in behind the payload for the rest of the frame
  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      shiftR <= '0;
      sdataR <= 1'b0;
      syncR  <= 1'b0;
    end else begin
      syncR <= strobe.inTag;
      if (strobe.frameStart) begin
        sdataR <= loadVec[PAY_W-1];
        shiftR <= {loadVec[PAY_W-2:0], 1'b0};
      end else begin
        sdataR <= shiftR[PAY_W-1];
        shiftR <= {shiftR[PAY_W-2:0], 1'b0};
      end
    end
  end

  assign sdata     = sdataR;
  assign frameSync = syncR;
  assign bufFull   = fullR;
  assign underrun  = urR;

endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_tx_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int TAG_W      = 16,
  parameter int SLOTS      = 4,
  parameter int SLOT_W     = 20,
  parameter int WR_W       = 32
) (
  input  logic                     bitClk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [$clog2(SLOTS)-1:0] wrSlot,
  input  logic [WR_W-1:0]          wrData,
  input  logic [SLOTS-1:0]         slotReq,
  input  logic [SLOTS-1:0]         urClr,
  output logic                     sdata,
  output logic                     frameSync,
  output logic [SLOTS-1:0]         bufFull,
  output logic [SLOTS-1:0]         underrun
);

  txStrobe_t strobe;

  aclink_tx_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .TAG_W     (TAG_W)
  ) u_ctrl (
    .bitClk(bitClk),
    .rstN  (rstN),
    .strobe(strobe)
  );

  aclink_tx_dpath #(
    .SLOTS (SLOTS),
    .SLOT_W(SLOT_W),
    .TAG_W (TAG_W),
    .WR_W  (WR_W)
  ) u_dpath (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrEn     (wrEn),
    .wrSlot   (wrSlot),
    .wrData   (wrData),
    .slotReq  (slotReq),
    .urClr    (urClr),
    .sdata    (sdata),
    .frameSync(frameSync),
    .bufFull  (bufFull),
    .underrun (underrun)
  );

endmodule

// File: rtl/aclink_tx_checker.sv
module aclink_tx_checker #(
  parameter int SLOTS = 4
) (
  input logic                     bitClk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [$clog2(SLOTS)-1:0] wrSlot,
  input logic [SLOTS-1:0]         urClr,
  input logic                     frameSync,
  input logic [SLOTS-1:0]         bufFull,
  input logic [SLOTS-1:0]         underrun
);

  // R1: each sync pulse is exactly 16 bit times wide
  a_r1_sync_width: assert property (@(posedge bitClk) disable iff (!rstN)
    $fell(frameSync) |-> ($past(frameSync, 16) && !$past(frameSync, 17)));

  // R5: a write leaves the addressed slot marked full
  a_r5_write_sets_full: assert property (@(posedge bitClk) disable iff (!rstN)
    wrEn |=> bufFull[$past(wrSlot)]);

  // R6: full flags drop only on the frame-start edge
  a_r6_full_drops_at_start: assert property (@(posedge bitClk) disable iff (!rstN)
    (|($past(bufFull) & ~bufFull)) |-> $rose(frameSync));

  // R7: an underrun flag rises only on the frame-start edge
  a_r7_underrun_at_start: assert property (@(posedge bitClk) disable iff (!rstN)
    (|(~$past(underrun) & underrun)) |-> $rose(frameSync));

  // R8: an underrun flag falls only where its clear was given
  a_r8_underrun_sticky: assert property (@(posedge bitClk) disable iff (!rstN)
    ((($past(underrun) & ~$past(urClr)) & ~underrun) == '0));

endmodule

bind aclink_tx_framer aclink_tx_checker #(.SLOTS(SLOTS)) u_chk (
  .bitClk   (bitClk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrSlot   (wrSlot),
  .urClr    (urClr),
  .frameSync(frameSync),
  .bufFull  (bufFull),
  .underrun (underrun)
);

// File: tb/aclink_tx_framer_bench.sv
module aclink_tx_framer_bench;

  localparam int NF = 40;

  logic        bitClk = 1'b0;
  logic        rstN   = 1'b0;
  logic        wrEn   = 1'b0;
  logic [1:0]  wrSlot = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  slotReq = '0;
  logic [3:0]  urClr  = '0;
  logic        sdata;
  logic        frameSync;
  logic [3:0]  bufFull;
  logic [3:0]  underrun;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 0;

  always #5 bitClk = ~bitClk;

  aclink_tx_framer u_aclink_tx_framer (
    .bitClk(bitClk), .rstN(rstN), .wrEn(wrEn), .wrSlot(wrSlot),
    .wrData(wrData), .slotReq(slotReq), .urClr(urClr),
    .sdata(sdata), .frameSync(frameSync), .bufFull(bufFull),
    .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] reqOf(input int f);
    return 4'(f % 16);
  endfunction
  function automatic logic [3:0] midMask(input int f);
    return (f % 4 == 3) ? 4'h0 : 4'((f * 5 + 3) % 16);
  endfunction
  function automatic logic [19:0] dataOf(input int f, input int i);
    return 20'((f * 13 + 7) * (i + 3) * 977);
  endfunction
  function automatic logic [19:0] lateData(input int f);
    return 20'(f * 40503 + 11);
  endfunction
  function automatic bit lateOf(input int f);
    return (f % 5 == 2);
  endfunction
  function automatic logic [3:0] lateClr(input int f);
    return (f % 6 == 5) ? 4'hF : 4'h0;
  endfunction
  function automatic logic [3:0] midClr(input int f);
    return (f % 9 == 0) ? 4'hF : ((f % 3 == 0) ? 4'b0101 : 4'h0);
  endfunction

  initial begin
    repeat (200000) @(posedge bitClk);
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [19:0]  mHold [4];
    logic [3:0]   mFull, mUr, reqCur, newUr, lateClrP;
    logic         lateP;
    logic [19:0]  lateDataP;
    logic [255:0] expFrame, gotData, gotSync;
    logic [255:0] expSync;
    logic [3:0]   endFull, endUr;

    for (int i = 0; i < 4; i++) mHold[i] = '0;
    mFull = '0; mUr = '0; lateP = 0; lateDataP = '0; lateClrP = '0;
    reqCur = reqOf(0);
    slotReq = reqCur;
    expSync = {16'hFFFF, 240'b0};

    // R10: outputs at rest while reset is held
    repeat (3) @(posedge bitClk);
    @(negedge bitClk);
    check({sdata, frameSync, bufFull, underrun} == 10'b0, "R10 reset outputs",
          256'({sdata, frameSync, bufFull, underrun}), 256'b0);
    rstN = 1'b1;

    for (int f = 0; f < NF; f++) begin
      // Expected frame from state before this frame's start edge
      expFrame = '0;
      expFrame[255] = |reqCur;
      for (int i = 0; i < 4; i++) begin
        expFrame[254 - i] = reqCur[i];
        if (reqCur[i]) expFrame[255 - 16 - 20 * i -: 20] = mHold[i];
      end
      newUr = reqCur & ~mFull;
      mFull = mFull & ~reqCur;
      if (lateP) begin
        mHold[0] = lateDataP;
        mFull[0] = 1'b1;
      end
      mUr = (mUr & ~lateClrP) | newUr;

      for (int b = 0; b < 256; b++) begin
        @(posedge bitClk);
        @(negedge bitClk);
        gotData[255 - b] = sdata;
        gotSync[255 - b] = frameSync;
        if (b == 255) begin
          endFull = bufFull;
          endUr   = underrun;
        end
        wrEn  = 1'b0;
        urClr = '0;
        if (b >= 100 && b < 104 && midMask(f)[b - 100]) begin
          wrEn   = 1'b1;
          wrSlot = 2'(b - 100);
          wrData = {12'(f + (b - 100) * 5 + 1), dataOf(f, b - 100)};
        end
        if (b == 110) slotReq = reqOf(f + 1);
        if (b == 120) urClr = midClr(f);
        if (b == 255) begin
          if (lateOf(f)) begin
            wrEn   = 1'b1;
            wrSlot = 2'd0;
            wrData = {12'hABC, lateData(f)};
          end
          urClr = lateClr(f);
        end
      end

      // R1: sync shape and frame alignment
      check(gotSync == expSync, "R1 sync pattern", gotSync, expSync);
      // R2: tag slot
      check(gotData[255 -: 16] == expFrame[255 -: 16], "R2 tag bits",
            256'(gotData[255 -: 16]), 256'(expFrame[255 -: 16]));
      // R3 and R4: whole serial frame, payload placement and zero fill
      check(gotData == expFrame, "R3/R4 frame contents", gotData, expFrame);
      // R9: write on the previous start edge did not alter slot 1 data
      if (lateP && reqCur[0])
        check(gotData[239 -: 20] == expFrame[239 -: 20], "R9 start-edge write",
              256'(gotData[239 -: 20]), 256'(expFrame[239 -: 20]));

      for (int i = 0; i < 4; i++) begin
        if (midMask(f)[i]) begin
          mHold[i] = dataOf(f, i);
          mFull[i] = 1'b1;
        end
      end
      mUr = mUr & ~midClr(f);

      // R5 and R6: full flags after start clear and in-frame writes
      check(endFull == mFull, "R5/R6 buffer full", 256'(endFull), 256'(mFull));
      // R7 and R8: underrun flags after start and clear pulses
      check(endUr == mUr, "R7/R8 underrun", 256'(endUr), 256'(mUr));

      lateP     = lateOf(f);
      lateDataP = lateData(f);
      lateClrP  = lateClr(f);
      reqCur    = reqOf(f + 1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule